// File: doc/BRIEF.md
# Five-Round Block Cipher Core

This block encrypts one 128-bit block at a time with a shortened AES-style schedule. A 128-bit key and a 128-bit plaintext arrive as four 32-bit words on two parallel input ports. The core then performs an initial key addition, four full rounds and one final round, and returns the ciphertext as four 32-bit words. Round keys are derived on the fly, one expansion per round, so no key schedule is stored.

A single round unit is reused across five clock cycles. A host waits for `ready`, presents four qualified words, and collects four words marked by `valid_out`. Words presented while the core is busy are discarded.

Top module: `aes5_core`

## Requirements
- R1: A synchronous active-high reset forces `valid_out` low and `ready` high from the first clock edge at which `rst` is sampled high.
- R2: While `ready` is high, each cycle with `valid_in` high captures one word from `text_in` and one from `key_in`. The first captured word is bits 127:96 of the block and the key, and the fourth is bits 31:0. Idle cycles between beats are allowed and capture nothing.
- R3: `ready` falls at the edge that captures the fourth word and stays low until the ciphertext has been delivered. `valid_in` and the input words have no effect while `ready` is low.
- R4: The ciphertext is computed as follows. First the plaintext is XORed with the key. Then four rounds apply byte substitution, row shifting, column mixing and round-key addition, in that order. A fifth round skips column mixing. Each round key comes from the previous one by the AES-128 expansion step, using round constants 01, 02, 04, 08 and 10 (hex) in turn.
- R5: Byte k of the state sits at bits 127-8k down to 120-8k. Bytes fill columns of four (column c holds bytes 4c..4c+3). Row shifting rotates row r left by r columns. Column mixing uses the standard coefficient matrix with doubling done as shift-left and XOR with 1B hex on carry.
- R6: `valid_out` first rises at the fifth rising edge after the edge that captured the fourth input word.
- R7: The ciphertext is driven on four consecutive cycles with `valid_out` high, bits 127:96 first.
- R8: `ready` returns high at the same edge at which `valid_out` falls. The two are never high together.
- R9: A reset during a partial load discards the words already captured; the next block loads from its first word.
- R10: Byte substitution is the standard AES S-box: multiplicative inverse in GF(2^8) modulo 11B hex, followed by the affine map with constant 63 hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Qualifies the words on `text_in` and `key_in` |
| text_in | input | 32 | Plaintext word |
| key_in | input | 32 | Key word |
| ready | output | 1 | Core can accept a new block |
| valid_out | output | 1 | Qualifies `text_out` |
| text_out | output | 32 | Ciphertext word |

## Verification
Every result has a fixed position in time.
- `ready` must be low at the falling edge that follows the fourth capture.
- The first ciphertext word is due exactly five rising edges later, so the bench counts edges from that capture and requires a count of five.
- The remaining three words must follow on the next three edges.
- `ready` must be back high, with `valid_out` low, one edge after the last word.

All samples are taken at falling edges, halfway between the register updates. Blocks are sent with back-to-back beats, with idle gaps, and with junk beats while the core is busy, and each ciphertext is compared against a software model of the same five-round schedule.

// File: rtl/aes5_pkg.sv
`timescale 1ns/1ps
package aes5_pkg;

  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_DRAIN} aes5_phase_t;

  // Doubling in GF(2^8) modulo x^8+x^4+x^3+x+1.
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_x2(p);
    end
    return acc;
  endfunction

  // Substitution: inverse as a^254 by an addition chain, then the affine map.
  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] x2, x3, x12, x15, x240, inv;
    x2   = gf_mul(a, a);
    x3   = gf_mul(x2, a);
    x12  = gf_mul(gf_mul(x3, x3), gf_mul(x3, x3));
    x15  = gf_mul(x12, x3);
    x240 = gf_mul(x15, x15);
    x240 = gf_mul(x240, x240);
    x240 = gf_mul(x240, x240);
    x240 = gf_mul(x240, x240);
    inv  = gf_mul(gf_mul(x240, x12), x2);
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes5_round.sv
`timescale 1ns/1ps
module aes5_round import aes5_pkg::*; #(
  parameter int BLOCK_W = 128
) (
  input  logic [BLOCK_W-1:0] state_i,
  input  logic [BLOCK_W-1:0] rkey_i,
  input  logic               mix_en,
  output logic [BLOCK_W-1:0] state_o
);
  localparam int NBYTES = BLOCK_W / 8;
  localparam int NCOLS  = NBYTES / 4;

  logic [7:0] subd [NBYTES];
  logic [7:0] shft [NBYTES];
  logic [7:0] mixd [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    assign subd[b] = sub_byte(state_i[BLOCK_W-1-8*b -: 8]);
  end

  // Row r of the output takes the byte r columns to the right.
  for (genvar b = 0; b < NBYTES; b++) begin : g_shift
    localparam int COL = b / 4;
    localparam int ROW = b % 4;
    localparam int SRC = 4 * ((COL + ROW) % NCOLS) + ROW;
    assign shft[b] = subd[SRC];
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_mix
    logic [7:0] a0, a1, a2, a3;
    assign a0 = shft[4*c];
    assign a1 = shft[4*c+1];
    assign a2 = shft[4*c+2];
    assign a3 = shft[4*c+3];
    assign mixd[4*c]   = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
    assign mixd[4*c+1] = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
    assign mixd[4*c+2] = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
    assign mixd[4*c+3] = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_add
    assign state_o[BLOCK_W-1-8*b -: 8] = (mix_en ? mixd[b] : shft[b]) ^ rkey_i[BLOCK_W-1-8*b -: 8];
  end
endmodule

// File: rtl/aes5_keystep.sv
`timescale 1ns/1ps
module aes5_keystep import aes5_pkg::*; #(
  parameter int KEY_W = 128
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [7:0]       rcon_i,
  output logic [KEY_W-1:0] key_o
);
  localparam int NKW = KEY_W / 32;

  logic [31:0] w_in  [NKW];
  logic [31:0] w_out [NKW];
  logic [31:0] rot, subw, tmix;

  for (genvar i = 0; i < NKW; i++) begin : g_split
    assign w_in[i] = key_i[KEY_W-1-32*i -: 32];
  end

  assign rot = {w_in[NKW-1][23:0], w_in[NKW-1][31:24]};

  for (genvar j = 0; j < 4; j++) begin : g_subw
    assign subw[31-8*j -: 8] = sub_byte(rot[31-8*j -: 8]);
  end

  assign tmix = subw ^ {rcon_i, 24'h0};

  for (genvar i = 0; i < NKW; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign w_out[i] = w_in[i] ^ tmix;
    end else begin : g_rest
      assign w_out[i] = w_in[i] ^ w_out[i-1];
    end
    assign key_o[KEY_W-1-32*i -: 32] = w_out[i];
  end
endmodule

// File: rtl/aes5_core.sv
`timescale 1ns/1ps
module aes5_core import aes5_pkg::*; #(
  parameter int WORD_W     = 32,
  parameter int NUM_WORDS  = 4,
  parameter int NUM_ROUNDS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [WORD_W-1:0] text_in,
  input  logic [WORD_W-1:0] key_in,
  output logic              ready,
  output logic              valid_out,
  output logic [WORD_W-1:0] text_out
);
  localparam int BLOCK_W = WORD_W * NUM_WORDS;
  localparam int WCNT_W  = $clog2(NUM_WORDS);
  localparam int RCNT_W  = $clog2(NUM_ROUNDS + 1);
  localparam logic [WCNT_W-1:0] LAST_W = WCNT_W'(NUM_WORDS - 1);
  localparam logic [RCNT_W-1:0] LAST_R = RCNT_W'(NUM_ROUNDS);

  aes5_phase_t         phase_q;
  logic [WCNT_W-1:0]   wcnt_q;
  logic [RCNT_W-1:0]   rnd_q;
  logic [7:0]          rcon_q;
  logic [BLOCK_W-1:0]  state_q, key_q;
  logic [WORD_W-1:0]   dout_q;
  logic                vout_q, rdy_q;

  logic [BLOCK_W-1:0]  text_cat, key_cat, key_next, round_out;

  assign text_cat = {state_q[BLOCK_W-WORD_W-1:0], text_in};
  assign key_cat  = {key_q[BLOCK_W-WORD_W-1:0], key_in};

  aes5_keystep #(.KEY_W(BLOCK_W)) u_key (
    .key_i (key_q),
    .rcon_i(rcon_q),
    .key_o (key_next)
  );

  aes5_round #(.BLOCK_W(BLOCK_W)) u_round (
    .state_i(state_q),
    .rkey_i (key_next),
    .mix_en (rnd_q != LAST_R),
    .state_o(round_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LOAD;
      wcnt_q  <= '0;
      rnd_q   <= '0;
      rcon_q  <= 8'h01;
      state_q <= '0;
      key_q   <= '0;
      dout_q  <= '0;
      vout_q  <= 1'b0;
      rdy_q   <= 1'b1;
    end else begin
      case (phase_q)
        PH_LOAD: if (valid_in) begin
          wcnt_q  <= wcnt_q + 1'b1;
          key_q   <= key_cat;
          state_q <= text_cat;
          if (wcnt_q == LAST_W) begin
            state_q <= text_cat ^ key_cat;
            wcnt_q  <= '0;
            rnd_q   <= RCNT_W'(1);
            rcon_q  <= 8'h01;
            rdy_q   <= 1'b0;
            phase_q <= PH_RUN;
          end
        end
        PH_RUN: begin
          key_q  <= key_next;
          rcon_q <= gf_x2(rcon_q);
          rnd_q  <= rnd_q + 1'b1;
          if (rnd_q == LAST_R) begin
            dout_q  <= round_out[BLOCK_W-1 -: WORD_W];
            state_q <= {round_out[BLOCK_W-WORD_W-1:0], {WORD_W{1'b0}}};
            vout_q  <= 1'b1;
            wcnt_q  <= '0;
            phase_q <= PH_DRAIN;
          end else begin
            state_q <= round_out;
          end
        end
        default: begin
          if (wcnt_q == LAST_W) begin
            vout_q  <= 1'b0;
            rdy_q   <= 1'b1;
            wcnt_q  <= '0;
            phase_q <= PH_LOAD;
          end else begin
            dout_q  <= state_q[BLOCK_W-1 -: WORD_W];
            state_q <= {state_q[BLOCK_W-WORD_W-1:0], {WORD_W{1'b0}}};
            wcnt_q  <= wcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ready     = rdy_q;
  assign valid_out = vout_q;
  assign text_out  = dout_q;

  // Checker counters: edges since the last capture, and words delivered.
  logic [RCNT_W:0] lat_cnt;
  logic [WCNT_W:0] out_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      out_cnt <= '0;
    end else begin
      if (ready && valid_in && wcnt_q == LAST_W) lat_cnt <= '0;
      else if (!ready && !valid_out)             lat_cnt <= lat_cnt + 1'b1;
      if (valid_out)  out_cnt <= out_cnt + 1'b1;
      else if (ready) out_cnt <= '0;
    end
  end

  p_busy_after_load_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && valid_in && wcnt_q == LAST_W) |=> !ready);
  p_first_word_latency_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_out) |-> lat_cnt == (RCNT_W+1)'(NUM_ROUNDS));
  p_four_words_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_out) |-> out_cnt == (WCNT_W+1)'(NUM_WORDS));
  p_ready_returns_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_out) |-> ready);
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(ready && valid_out));
  p_round_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN) |-> (rnd_q >= RCNT_W'(1) && rnd_q <= LAST_R));
endmodule

// File: tb/aes5_core_tb_top.sv
`timescale 1ns/1ps
module aes5_core_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_in;
  logic [31:0] text_in, key_in;
  logic        ready, valid_out;
  logic [31:0] text_out;

  always #5 clk = ~clk;

  aes5_core dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .text_in(text_in), .key_in(key_in),
    .ready(ready), .valid_out(valid_out), .text_out(text_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sbt [256];

  // Stimulus table: {plaintext, key}.
  localparam logic [255:0] VEC [6] = '{
    {128'h0, 128'h0},
    {{128{1'b1}}, {128{1'b1}}},
    {128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f},
    {128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c},
    {128'h0123456789abcdeffedcba9876543210, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0},
    {128'h80000000000000000000000000000001, 128'h00000000000000000000000000000080}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Carry-less product reduced modulo 0x11b.
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] k);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] rk [16];
    logic [7:0] tmp [4];
    logic [7:0] rc;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      rk[i] = k[127-8*i -: 8];
      s[i]  = pt[127-8*i -: 8] ^ rk[i];
    end
    rc = 8'h01;
    for (int r = 1; r <= 5; r++) begin
      tmp[0] = sbt[rk[13]] ^ rc;
      tmp[1] = sbt[rk[14]];
      tmp[2] = sbt[rk[15]];
      tmp[3] = sbt[rk[12]];
      for (int i = 0; i < 16; i++) rk[i] = rk[i] ^ ((i < 4) ? tmp[i] : rk[i-4]);
      rc = bmul(rc, 8'h02);
      for (int i = 0; i < 16; i++) t[i] = sbt[s[4*(((i/4) + (i%4)) % 4) + (i%4)]];
      for (int c = 0; c < 4; c++) begin
        if (r < 5) begin
          s[4*c]   = bmul(t[4*c],8'h02) ^ bmul(t[4*c+1],8'h03) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ bmul(t[4*c+1],8'h02) ^ bmul(t[4*c+2],8'h03) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ bmul(t[4*c+2],8'h02) ^ bmul(t[4*c+3],8'h03);
          s[4*c+3] = bmul(t[4*c],8'h03) ^ t[4*c+1] ^ t[4*c+2] ^ bmul(t[4*c+3],8'h02);
        end else begin
          for (int j = 0; j < 4; j++) s[4*c+j] = t[4*c+j];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // Sends one block, then checks the handshake, latency and result.
  task automatic run_block(input logic [127:0] pt, input logic [127:0] k, input bit gap, input bit noise);
    logic [127:0] ct, exp;
    int lat;
    bit contig;
    exp = ref_enc(pt, k);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      valid_in = 1'b1;
      text_in  = pt[127-32*i -: 32];
      key_in   = k[127-32*i -: 32];
      @(posedge clk);
      if (gap && i < 3) begin
        @(negedge clk);
        valid_in = 1'b0;            // idle beat with junk data (R2)
        text_in  = $urandom;
        key_in   = $urandom;
        @(posedge clk);
      end
    end
    @(negedge clk);
    valid_in = 1'b0;
    check(ready === 1'b0, "R3 ready low after fourth beat", 128'(ready), 128'd0);
    lat = 0;
    while (!valid_out && lat < 40) begin
      if (noise) begin                 // junk beats while busy (R3)
        valid_in = 1'b1;
        text_in  = $urandom;
        key_in   = $urandom;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check(lat == 5, "R6 edges to first word", 128'(lat), 128'd5);
    ct = '0;
    contig = 1'b1;
    for (int w = 0; w < 4; w++) begin
      if (w > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      contig = contig && (valid_out === 1'b1) && (ready === 1'b0);
      ct = {ct[95:0], text_out};
    end
    valid_in = 1'b0;
    check(contig, "R7 four consecutive words", 128'(contig), 128'd1);
    check(ct === exp, "R4/R5/R10 ciphertext", ct, exp);
    @(posedge clk);
    @(negedge clk);
    check(valid_out === 1'b0 && ready === 1'b1, "R8 idle after last word",
          {valid_out, ready}, 128'b01);
  endtask

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, y;
      inv = 8'h00;
      for (int c = 1; c < 256; c++) if (bmul(8'(x), 8'(c)) == 8'h01) inv = 8'(c);
      for (int i = 0; i < 8; i++)
        y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      sbt[x] = y;
    end

    rst = 1'b1; valid_in = 1'b0; text_in = '0; key_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid_out === 1'b0 && ready === 1'b1, "R1 reset state", {valid_out, ready}, 128'b01);
    rst = 1'b0;

    // Table walk: odd entries use gaps, entry 2 and 5 inject busy noise.
    for (int v = 0; v < 6; v++)
      run_block(VEC[v][255:128], VEC[v][127:0], (v % 2) == 1, (v == 2) || (v == 5));

    // R9: reset after two words of a block.
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      valid_in = 1'b1; text_in = $urandom; key_in = $urandom;
      @(posedge clk);
    end
    @(negedge clk);
    valid_in = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(valid_out === 1'b0 && ready === 1'b1, "R9 reset mid-load", {valid_out, ready}, 128'b01);
    rst = 1'b0;
    run_block(VEC[3][255:128], VEC[3][127:0], 1'b0, 1'b0);

    // R1: reset while rounds are running.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      valid_in = 1'b1; text_in = $urandom; key_in = $urandom;
      @(posedge clk);
    end
    @(negedge clk);
    valid_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(valid_out === 1'b0 && ready === 1'b1, "R1 reset during rounds", {valid_out, ready}, 128'b01);
    rst = 1'b0;
    run_block(VEC[4][255:128], VEC[4][127:0], 1'b1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule